// File: doc/BRIEF.md
# Card Transfer Command Launcher

This block starts one transfer on a memory-card bus each time the host writes a 32-bit command word. The word carries an 8-bit protocol code, a direction bit, a data-path select bit, wait-for-card-interrupt request bits and a short byte count. The block first sends the protocol code as one byte on a byte-serial card bus model. It then moves the data phase over one of two paths. The FIFO path moves block count × block size bytes between the card bus and an external byte FIFO. The short path moves up to eight bytes, packed little-endian, between the card bus and two 32-bit parameter registers, and uses no FIFO.

The block reports two sticky events: command done and transfer done. A `busy` flag covers the whole operation and drops only once both events are present. The host reads back the parameter registers directly. A command word written while an operation is running is dropped and raises a protocol-error flag.

Top module: `xfer_launch`

## Requirements
- R1: After reset, `busy`, `cmd_done`, `xfer_done`, `proto_err`, `cbus_tx_vld` and every bit of `prm_q` are 0.
- R2: A command word written while idle is accepted at that clock edge. In the next cycle `busy` is 1, and the protocol code from word bits 23:16 appears as the single byte on `cbus_tx_byte`, with `cbus_tx_vld` high for exactly that cycle.
- R3: Word bit 15 = 0 selects the short path and bit 14 = 1 selects a read. For a short write, the byte count is taken from bits 3:0, and any value above 8 counts as 8. After the code byte, that many bytes are sent one per cycle, in the order parameter byte 0, 1, and so on. Byte k is `prm_q[8k+7:8k]`, so bytes 0 to 3 come from register 0 and bytes 4 to 7 from register 1. A count of 0 sends only the code byte.
- R4: A short read clears all parameter bytes at acceptance. It stores received byte k into parameter byte k, using the same little-endian layout as R3. The stores are complete by the cycle in which `cmd_done` rises, and bytes beyond the count read 0.
- R5: Word bit 15 = 1 selects the FIFO path. The byte count is block count × block size, taken from the block register (count in bits 31:16, size in bits 11:0) as held at acceptance. A write pops one FIFO byte per sent byte, and sends only while `fifo_empty` is 0. A read raises `cbus_rx_rdy` only while `fifo_full` is 0, and pushes each received byte. A product of 0 skips the data phase.
- R6: On the FIFO path, `xfer_done` is set in the cycle after the last data byte. On the short path, `xfer_done` and `cmd_done` are set together when the operation ends.
- R7: When `serial_mode` = 0, word bit 13 makes the block wait after the data phase until `card_int` is 1, and bit 11 is ignored. When `serial_mode` = 1, bit 11 makes it wait, and bit 13 is ignored.
- R8: `busy` stays 1 from the cycle after acceptance until the operation ends. Without a wait and with data always ready, it lasts 1 + byte-count cycles. `cmd_done` is never 1 while `busy` is 1. Both events are cleared at acceptance and are both 1 once `busy` falls.
- R9: A command word written while `busy` is 1 is ignored and sets `proto_err`. `proto_err` stays set until the next accepted command clears it.
- R10: While idle, `prm_we[i]` loads parameter register i from `prm_wdata`. While busy, host parameter writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word |
| blk_we | input | 1 | Block register write strobe |
| blk_wdata | input | 32 | Block count (31:16) and block size (11:0) |
| prm_we | input | NPRM | Per-register parameter write strobes |
| prm_wdata | input | 32 | Parameter write data |
| prm_q | output | 32*NPRM | Parameter registers, register 0 in the low word |
| serial_mode | input | 1 | 1 selects serial bus mode for the interrupt-wait bit |
| busy | output | 1 | Operation in progress |
| cmd_done | output | 1 | Sticky end-of-command event |
| xfer_done | output | 1 | Sticky end-of-transfer event |
| proto_err | output | 1 | Sticky command-while-busy flag |
| cbus_tx_vld | output | 1 | Byte sent to card this cycle |
| cbus_tx_byte | output | 8 | Byte sent to card |
| cbus_rx_vld | input | 1 | Card offers a byte |
| cbus_rx_byte | input | 8 | Byte from card |
| cbus_rx_rdy | output | 1 | Block accepts a card byte this cycle |
| card_int | input | 1 | Card interrupt line |
| fifo_empty | input | 1 | Transmit FIFO has no byte |
| fifo_rdata | input | 8 | Head byte of transmit FIFO |
| fifo_pop | output | 1 | Consume head byte |
| fifo_full | input | 1 | Receive FIFO has no room |
| fifo_push | output | 1 | Write `fifo_wdata` into receive FIFO |
| fifo_wdata | output | 8 | Byte to receive FIFO |

## Verification
A wrong byte index or path choice shows up in the sent or stored byte stream in the same cycle, usually as a misordered or extra byte right after the code byte. A wrong length latch or a wrong clamp on the short count moves the cycle in which `busy` falls, so the exact busy length is measured for every dense case. Errors in the event flags or the wait logic become visible within one cycle of the data phase ending: `busy` falls early, falls late, or falls with one event still clear. A missed busy guard shows up at the parameter outputs or on `proto_err` as soon as the stray write lands.

// File: rtl/xl_pkg.sv
package xl_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_CODE,
      ST_DATA,
      ST_WAIT
   } xl_state_e;

   localparam int CODE_LSB  = 16;
   localparam int CODE_W    = 8;
   localparam int FIFO_BIT  = 15;
   localparam int DIR_BIT   = 14;
   localparam int PWAIT_BIT = 13;
   localparam int SWAIT_BIT = 11;
   localparam int SLEN_W    = 4;
   localparam int BCNT_LSB  = 16;

   typedef struct packed {
      logic [CODE_W-1:0] code;
      logic              fifo_path;
      logic              rd;
      logic              want_int;
      logic [SLEN_W-1:0] slen;
   } xl_cmd_t;

endpackage

// File: rtl/xl_decode.sv
module xl_decode
   import xl_pkg::*;
#(
   parameter int SHORT_MAX = 8,
   parameter int BCNT_W    = 16,
   parameter int BSIZE_W   = 12,
   localparam int LEN_W    = BCNT_W + BSIZE_W
) (
   input  logic [31:0]        word,
   input  logic               serial_mode,
   input  logic [BCNT_W-1:0]  blk_cnt,
   input  logic [BSIZE_W-1:0] blk_size,
   output xl_cmd_t            cmd,
   output logic [LEN_W-1:0]   len
);

   always_comb begin
      cmd.code      = word[CODE_LSB +: CODE_W];
      cmd.fifo_path = word[FIFO_BIT];
      cmd.rd        = word[DIR_BIT];
      cmd.want_int  = serial_mode ? word[SWAIT_BIT] : word[PWAIT_BIT];
      cmd.slen      = word[SLEN_W-1:0];
   end

   always_comb begin
      if (cmd.fifo_path)
         len = LEN_W'(blk_cnt) * LEN_W'(blk_size);
      else if (32'(cmd.slen) > SHORT_MAX)
         len = LEN_W'(SHORT_MAX);
      else
         len = LEN_W'(cmd.slen);
   end

endmodule

// File: rtl/xl_prm.sv
module xl_prm #(
   parameter int NPRM   = 2,
   localparam int NBYTE = NPRM * 4,
   localparam int IDX_W = $clog2(NBYTE),
   localparam int PW    = 32 * NPRM
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             busy,
   input  logic [NPRM-1:0]  we,
   input  logic [31:0]      wdata,
   input  logic             clr,
   input  logic             ld_en,
   input  logic [IDX_W-1:0] ld_idx,
   input  logic [7:0]       ld_byte,
   output logic [PW-1:0]    q
);

   for (genvar r = 0; r < NPRM; r++) begin : g_reg
      for (genvar b = 0; b < 4; b++) begin : g_byte
         localparam int K = r * 4 + b;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q[K*8 +: 8] <= '0;
            else if (clr)
               q[K*8 +: 8] <= '0;
            else if (!busy && we[r])
               q[K*8 +: 8] <= wdata[b*8 +: 8];
            else if (ld_en && ld_idx == IDX_W'(K))
               q[K*8 +: 8] <= ld_byte;
         end
      end
   end

   // R10: host writes have no effect while an operation runs
   a_r10_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !ld_en) |=> $stable(q));

endmodule

// File: rtl/xl_seq.sv
module xl_seq
   import xl_pkg::*;
#(
   parameter int LEN_W = 28,
   parameter int IDX_W = 3,
   parameter int PW    = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_we,
   input  xl_cmd_t          cmd,
   input  logic [LEN_W-1:0] len,
   input  logic [PW-1:0]    prm_q,
   input  logic             fifo_empty,
   input  logic [7:0]       fifo_rdata,
   input  logic             fifo_full,
   input  logic             rx_vld,
   input  logic [7:0]       rx_byte,
   input  logic             card_int,
   output logic             busy,
   output logic             cmd_done,
   output logic             xfer_done,
   output logic             proto_err,
   output logic             tx_vld,
   output logic [7:0]       tx_byte,
   output logic             rx_rdy,
   output logic             fifo_pop,
   output logic             fifo_push,
   output logic [7:0]       fifo_wdata,
   output logic             prm_clr,
   output logic             prm_ld,
   output logic [IDX_W-1:0] prm_idx,
   output logic [7:0]       prm_byte
);

   xl_state_e        state, state_nx;
   xl_cmd_t          cur;
   logic [LEN_W-1:0] len_r, idx;
   logic             accept, beat, last, fin;

   assign busy    = (state != ST_IDLE);
   assign accept  = cmd_we && !busy;
   assign prm_idx = idx[IDX_W-1:0];

   always_comb begin
      tx_vld = 1'b0;
      rx_rdy = 1'b0;
      if (state == ST_CODE)
         tx_vld = 1'b1;
      else if (state == ST_DATA) begin
         if (cur.rd)
            rx_rdy = cur.fifo_path ? !fifo_full : 1'b1;
         else
            tx_vld = cur.fifo_path ? !fifo_empty : 1'b1;
      end
   end

   always_comb begin
      if (state == ST_CODE)
         tx_byte = cur.code;
      else if (cur.fifo_path)
         tx_byte = fifo_rdata;
      else
         tx_byte = prm_q[{prm_idx, 3'b000} +: 8];
   end

   assign beat       = (state == ST_DATA) && (cur.rd ? (rx_vld && rx_rdy) : tx_vld);
   assign last       = beat && (idx == len_r - LEN_W'(1));
   assign fifo_pop   = beat && !cur.rd && cur.fifo_path;
   assign fifo_push  = beat && cur.rd && cur.fifo_path;
   assign fifo_wdata = rx_byte;
   assign prm_ld     = beat && cur.rd && !cur.fifo_path;
   assign prm_byte   = rx_byte;
   assign prm_clr    = accept && cmd.rd && !cmd.fifo_path;

   assign fin = ((state == ST_CODE) && (len_r == '0) && !cur.want_int)
             || (last && !cur.want_int)
             || ((state == ST_WAIT) && card_int);

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE: if (accept) state_nx = ST_CODE;
         ST_CODE: begin
            if (len_r != '0)   state_nx = ST_DATA;
            else if (fin)      state_nx = ST_IDLE;
            else               state_nx = ST_WAIT;
         end
         ST_DATA: begin
            if (fin)           state_nx = ST_IDLE;
            else if (last)     state_nx = ST_WAIT;
         end
         ST_WAIT: if (fin) state_nx = ST_IDLE;
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cur       <= '0;
         len_r     <= '0;
         idx       <= '0;
         cmd_done  <= 1'b0;
         xfer_done <= 1'b0;
         proto_err <= 1'b0;
      end else begin
         state <= state_nx;
         if (accept) begin
            cur       <= cmd;
            len_r     <= len;
            idx       <= '0;
            cmd_done  <= 1'b0;
            xfer_done <= 1'b0;
            proto_err <= 1'b0;
         end else begin
            if (cmd_we) proto_err <= 1'b1;
            if (beat) idx <= idx + LEN_W'(1);
            if (last && cur.fifo_path) xfer_done <= 1'b1;
            if (fin) begin
               cmd_done  <= 1'b1;
               xfer_done <= 1'b1;
            end
         end
      end
   end

   // R8: both events present when the operation ends
   a_r8_end_events: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (cmd_done && xfer_done));
   // R8: command event never visible during an operation
   a_r8_no_early_done: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_done && busy));
   // R9: stray command word flags a protocol error
   a_r9_stray_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_we) |=> proto_err);
   // R2: first busy cycle sends the code byte
   a_r2_code_first: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> tx_vld);
   // R5: a pop always pairs with a sent byte, a push with an offered byte
   a_r5_pop_pair: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_pop |-> (tx_vld && !fifo_empty));
   a_r5_push_pair: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_push |-> (rx_vld && !fifo_full));
   // R7: waiting holds busy until the card interrupt
   a_r7_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT && !card_int) |=> busy);

endmodule

// File: rtl/xfer_launch.sv
module xfer_launch
   import xl_pkg::*;
#(
   parameter int BCNT_W  = 16,
   parameter int BSIZE_W = 12,
   parameter int NPRM    = 2,
   localparam int SHORT_MAX = NPRM * 4,
   localparam int LEN_W     = BCNT_W + BSIZE_W,
   localparam int IDX_W     = $clog2(SHORT_MAX),
   localparam int PW        = 32 * NPRM
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmd_we,
   input  logic [31:0]     cmd_wdata,
   input  logic            blk_we,
   input  logic [31:0]     blk_wdata,
   input  logic [NPRM-1:0] prm_we,
   input  logic [31:0]     prm_wdata,
   output logic [PW-1:0]   prm_q,
   input  logic            serial_mode,
   output logic            busy,
   output logic            cmd_done,
   output logic            xfer_done,
   output logic            proto_err,
   output logic            cbus_tx_vld,
   output logic [7:0]      cbus_tx_byte,
   input  logic            cbus_rx_vld,
   input  logic [7:0]      cbus_rx_byte,
   output logic            cbus_rx_rdy,
   input  logic            card_int,
   input  logic            fifo_empty,
   input  logic [7:0]      fifo_rdata,
   output logic            fifo_pop,
   input  logic            fifo_full,
   output logic            fifo_push,
   output logic [7:0]      fifo_wdata
);

   if (NPRM < 1 || NPRM > 3) begin : g_bad_nprm
      $error("NPRM must be 1..3 so the short count fits the 4-bit field");
   end
   if (BCNT_W < 1 || BCNT_W > 16) begin : g_bad_bcnt
      $error("BCNT_W must be 1..16");
   end
   if (BSIZE_W < 1 || BSIZE_W > 12) begin : g_bad_bsize
      $error("BSIZE_W must be 1..12");
   end

   logic [BCNT_W-1:0]  blk_cnt;
   logic [BSIZE_W-1:0] blk_size;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         blk_cnt  <= '0;
         blk_size <= '0;
      end else if (blk_we) begin
         blk_cnt  <= blk_wdata[BCNT_LSB +: BCNT_W];
         blk_size <= blk_wdata[BSIZE_W-1:0];
      end
   end

   xl_cmd_t          cmd;
   logic [LEN_W-1:0] len;
   logic             prm_clr, prm_ld;
   logic [IDX_W-1:0] prm_idx;
   logic [7:0]       prm_byte;

   xl_decode #(.SHORT_MAX(SHORT_MAX), .BCNT_W(BCNT_W), .BSIZE_W(BSIZE_W)) i_dec (
      .word        (cmd_wdata),
      .serial_mode (serial_mode),
      .blk_cnt     (blk_cnt),
      .blk_size    (blk_size),
      .cmd         (cmd),
      .len         (len)
   );

   xl_seq #(.LEN_W(LEN_W), .IDX_W(IDX_W), .PW(PW)) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_we     (cmd_we),
      .cmd        (cmd),
      .len        (len),
      .prm_q      (prm_q),
      .fifo_empty (fifo_empty),
      .fifo_rdata (fifo_rdata),
      .fifo_full  (fifo_full),
      .rx_vld     (cbus_rx_vld),
      .rx_byte    (cbus_rx_byte),
      .card_int   (card_int),
      .busy       (busy),
      .cmd_done   (cmd_done),
      .xfer_done  (xfer_done),
      .proto_err  (proto_err),
      .tx_vld     (cbus_tx_vld),
      .tx_byte    (cbus_tx_byte),
      .rx_rdy     (cbus_rx_rdy),
      .fifo_pop   (fifo_pop),
      .fifo_push  (fifo_push),
      .fifo_wdata (fifo_wdata),
      .prm_clr    (prm_clr),
      .prm_ld     (prm_ld),
      .prm_idx    (prm_idx),
      .prm_byte   (prm_byte)
   );

   xl_prm #(.NPRM(NPRM)) i_prm (
      .clk     (clk),
      .rst_n   (rst_n),
      .busy    (busy),
      .we      (prm_we),
      .wdata   (prm_wdata),
      .clr     (prm_clr),
      .ld_en   (prm_ld),
      .ld_idx  (prm_idx),
      .ld_byte (prm_byte),
      .q       (prm_q)
   );

endmodule

// File: tb/test_xfer_launch.sv
module test_xfer_launch;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_we = 1'b0;
   logic [31:0] cmd_wdata = '0;
   logic        blk_we = 1'b0;
   logic [31:0] blk_wdata = '0;
   logic [1:0]  prm_we = '0;
   logic [31:0] prm_wdata = '0;
   logic [63:0] prm_q;
   logic        serial_mode = 1'b0;
   logic        busy, cmd_done, xfer_done, proto_err;
   logic        cbus_tx_vld, cbus_rx_rdy, fifo_pop, fifo_push;
   logic [7:0]  cbus_tx_byte, fifo_wdata;
   logic        cbus_rx_vld = 1'b0;
   logic [7:0]  cbus_rx_byte = '0;
   logic        card_int = 1'b0;
   logic        fifo_empty = 1'b1;
   logic [7:0]  fifo_rdata = '0;
   logic        fifo_full = 1'b0;

   always #10 clk = ~clk;

   xfer_launch i_xfer_launch (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
      .blk_we(blk_we), .blk_wdata(blk_wdata), .prm_we(prm_we), .prm_wdata(prm_wdata),
      .prm_q(prm_q), .serial_mode(serial_mode), .busy(busy), .cmd_done(cmd_done),
      .xfer_done(xfer_done), .proto_err(proto_err), .cbus_tx_vld(cbus_tx_vld),
      .cbus_tx_byte(cbus_tx_byte), .cbus_rx_vld(cbus_rx_vld), .cbus_rx_byte(cbus_rx_byte),
      .cbus_rx_rdy(cbus_rx_rdy), .card_int(card_int), .fifo_empty(fifo_empty),
      .fifo_rdata(fifo_rdata), .fifo_pop(fifo_pop), .fifo_full(fifo_full),
      .fifo_push(fifo_push), .fifo_wdata(fifo_wdata)
   );

   int checks = 0;
   int errors = 0;

   logic [7:0] fq [0:255];
   logic [7:0] rx_src [0:255];
   logic [7:0] tx_log [0:255];
   logic [7:0] push_log [0:255];
   int fq_rd, fq_wr, rx_i, tx_n, push_n;
   bit rx_gap, tx_gap, full_gap;
   int int_at;
   int cyc_used;
   bit early_xd, done_in_busy;

   initial begin
      repeat (150000) @(posedge clk);
      $display("FAIL watchdog (all requirements): actual hung, expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
      $finish;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mkw(input logic [7:0] code, input bit fifo, input bit rd,
                                       input bit pw, input bit sw, input logic [3:0] n);
      return {8'h00, code, fifo, rd, pw, 1'b0, sw, 7'b0, n};
   endfunction

   function automatic logic [7:0] pbyte(input int k, input int salt);
      return 8'((k * 16 + salt) & 255);
   endfunction

   task automatic set_prm(input logic [31:0] p0, input logic [31:0] p1);
      @(negedge clk); prm_we = 2'b11; prm_wdata = p0;
      prm_we = 2'b01;
      @(negedge clk); prm_we = 2'b10; prm_wdata = p1;
      @(negedge clk); prm_we = 2'b00;
   endtask

   task automatic set_blk(input int cnt, input int size);
      @(negedge clk); blk_we = 1'b1; blk_wdata = {16'(cnt), 4'h0, 12'(size)};
      @(negedge clk); blk_we = 1'b0;
   endtask

   task automatic run(input logic [31:0] w);
      @(negedge clk);
      cmd_we = 1'b1; cmd_wdata = w;
      tx_n = 0; push_n = 0; rx_i = 0; fq_rd = 0;
      cyc_used = -1; early_xd = 0; done_in_busy = 0;
      @(negedge clk);
      cmd_we = 1'b0;
      for (int c = 0; c < 3000; c++) begin
         fifo_empty   = (fq_rd >= fq_wr) || (tx_gap && (c % 3 == 1));
         fifo_rdata   = fq[fq_rd & 255];
         fifo_full    = full_gap && (c % 3 == 2);
         cbus_rx_vld  = !(rx_gap && (c % 2 == 1));
         cbus_rx_byte = rx_src[rx_i & 255];
         card_int     = (int_at >= 0) && (c >= int_at);
         #1;
         if (!busy) begin
            cyc_used = c;
            break;
         end
         if (cmd_done) done_in_busy = 1;
         if (xfer_done) early_xd = 1;
         if (cbus_tx_vld) begin tx_log[tx_n & 255] = cbus_tx_byte; tx_n++; end
         if (fifo_pop) fq_rd++;
         if (fifo_push) begin push_log[push_n & 255] = fifo_wdata; push_n++; end
         if (cbus_rx_rdy && cbus_rx_vld) rx_i++;
         @(negedge clk);
      end
      card_int = 1'b0; cbus_rx_vld = 1'b0; fifo_empty = 1'b1; fifo_full = 1'b0;
   endtask

   task automatic end_checks(input string req, input int exp_cyc);
      chk(cmd_done && xfer_done, "R8", {req, " both events at end"}, {cmd_done, xfer_done}, 2'b11);
      chk(!done_in_busy, "R8", {req, " cmd_done during busy"}, done_in_busy, 0);
      if (exp_cyc >= 0)
         chk(cyc_used == exp_cyc, "R8", {req, " busy length"}, cyc_used, exp_cyc);
   endtask

   initial begin
      int_at = -1; rx_gap = 0; tx_gap = 0; full_gap = 0; fq_wr = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(!busy && !cmd_done && !xfer_done && !proto_err && !cbus_tx_vld && prm_q == 64'h0,
          "R1", "reset state", {busy, cmd_done, xfer_done, proto_err, cbus_tx_vld}, 0);

      // R3: short write sweep, counts 0..10
      for (int n = 0; n <= 10; n++) begin
         logic [31:0] p0, p1;
         int eff;
         bit ok;
         eff = (n > 8) ? 8 : n;
         p0 = {pbyte(3, n), pbyte(2, n), pbyte(1, n), pbyte(0, n)};
         p1 = {pbyte(7, n), pbyte(6, n), pbyte(5, n), pbyte(4, n)};
         set_prm(p0, p1);
         chk(prm_q == {p1, p0}, "R10", "idle parameter write", prm_q, {p1, p0});
         run(mkw(8'h40 + 8'(n), 0, 0, 0, 0, 4'(n)));
         chk(tx_n == 1 + eff, "R3", "short write byte count", tx_n, 1 + eff);
         chk(tx_log[0] == 8'h40 + 8'(n), "R2", "code byte first", tx_log[0], 8'h40 + n);
         ok = 1;
         for (int k = 0; k < eff; k++)
            if (tx_log[1 + k] != pbyte(k, n)) ok = 0;
         chk(ok, "R3", "short write byte order", n, eff);
         chk(prm_q == {p1, p0}, "R3", "write leaves params", prm_q, {p1, p0});
         end_checks("R3", 1 + eff);
      end

      // R4: short read sweep, counts 0..10, with and without card gaps
      for (int n = 0; n <= 10; n++) begin
         logic [63:0] expv;
         int eff;
         eff = (n > 8) ? 8 : n;
         set_prm(32'hFFFF_FFFF, 32'hFFFF_FFFF);
         rx_gap = n[0];
         expv = '0;
         for (int k = 0; k < 8; k++) begin
            rx_src[k] = 8'((8'hC0 ^ (k * 37 + n)) & 255);
            if (k < eff) expv[k*8 +: 8] = rx_src[k];
         end
         run(mkw(8'h80 + 8'(n), 0, 1, 0, 0, 4'(n)));
         chk(tx_n == 1 && tx_log[0] == 8'h80 + 8'(n), "R2", "read sends only code", tx_n, 1);
         chk(prm_q == expv, "R4", "short read packing", prm_q, expv);
         end_checks("R4", rx_gap ? -1 : 1 + eff);
      end
      rx_gap = 0;

      // R5: FIFO write sweep over block count and size
      for (int bc = 0; bc <= 3; bc++) begin
         for (int bs = 0; bs <= 4; bs++) begin
            int tot;
            bit ok;
            tot = bc * bs;
            set_blk(bc, bs);
            for (int i = 0; i < tot; i++) fq[i] = 8'((i * 7 + bc * 5 + bs) & 255);
            fq_wr = tot;
            tx_gap = (bs % 2 == 1);
            run(mkw(8'h21, 1, 0, 0, 0, 4'h3));
            ok = (tx_n == 1 + tot) && (tx_log[0] == 8'h21) && (fq_rd == tot);
            for (int i = 0; i < tot; i++) if (tx_log[1 + i] != fq[i]) ok = 0;
            chk(ok, "R5", "fifo write stream", tx_n, 1 + tot);
            end_checks("R5", tx_gap ? -1 : 1 + tot);
         end
      end
      tx_gap = 0; fq_wr = 0;

      // R5: FIFO read sweep with full and card stalls
      for (int bc = 1; bc <= 3; bc++) begin
         for (int bs = 1; bs <= 3; bs++) begin
            int tot;
            bit ok;
            tot = bc * bs;
            set_blk(bc, bs);
            for (int i = 0; i < tot; i++) rx_src[i] = 8'((i * 11 + bc + 3 * bs) & 255);
            full_gap = (bc != 2);
            rx_gap = (bs == 2);
            set_prm(32'h1234_5678, 32'h9ABC_DEF0);
            run(mkw(8'h33, 1, 1, 0, 0, 4'h0));
            ok = (push_n == tot) && (rx_i == tot) && (tx_n == 1);
            for (int i = 0; i < tot; i++) if (push_log[i] != rx_src[i]) ok = 0;
            chk(ok, "R5", "fifo read stream", push_n, tot);
            chk(prm_q == 64'h9ABC_DEF0_1234_5678, "R5", "fifo read keeps params", prm_q, 64'h9ABC_DEF0_1234_5678);
            end_checks("R5", (full_gap || rx_gap) ? -1 : 1 + tot);
         end
      end
      full_gap = 0; rx_gap = 0;

      // R6 + R7: parallel wait on bit 13, fifo write of 2 bytes, interrupt at cycle 5
      set_blk(1, 2);
      fq[0] = 8'h5A; fq[1] = 8'hA5; fq_wr = 2;
      serial_mode = 0; int_at = 5;
      run(mkw(8'h44, 1, 0, 1, 0, 4'h0));
      chk(cyc_used == 6, "R7", "parallel wait length", cyc_used, 6);
      chk(early_xd, "R6", "xfer_done before command end", early_xd, 1);
      end_checks("R7", 6);

      // R7: parallel mode ignores bit 11
      int_at = -1;
      run(mkw(8'h45, 1, 0, 0, 1, 4'h0));
      chk(cyc_used == 3, "R7", "bit 11 ignored in parallel mode", cyc_used, 3);

      // R7: serial mode ignores bit 13
      serial_mode = 1;
      run(mkw(8'h46, 1, 0, 1, 0, 4'h0));
      chk(cyc_used == 3, "R7", "bit 13 ignored in serial mode", cyc_used, 3);

      // R7 + R6: serial wait on bit 11, short write of 1 byte
      int_at = 4;
      run(mkw(8'h47, 0, 0, 0, 1, 4'h1));
      chk(cyc_used == 5, "R7", "serial wait length", cyc_used, 5);
      chk(!early_xd, "R6", "short path xfer_done not early", early_xd, 0);
      end_checks("R6", 5);
      int_at = -1; serial_mode = 0; fq_wr = 0;

      // R9 + R10: stray command and parameter write during a short read
      set_prm(32'h0, 32'h0);
      @(negedge clk);
      cmd_we = 1'b1; cmd_wdata = mkw(8'h6C, 0, 1, 0, 0, 4'h4);
      cbus_rx_vld = 1'b0;
      @(negedge clk);
      cmd_we = 1'b0;
      chk(busy && cbus_tx_vld && cbus_tx_byte == 8'h6C, "R2", "code cycle", cbus_tx_byte, 8'h6C);
      @(negedge clk);
      cmd_we = 1'b1; cmd_wdata = mkw(8'h99, 1, 0, 0, 0, 4'h0);
      prm_we = 2'b11; prm_wdata = 32'hFFFF_FFFF;
      @(negedge clk);
      cmd_we = 1'b0; prm_we = 2'b00;
      #1;
      chk(proto_err && busy && !cbus_tx_vld, "R9", "stray command ignored",
          {proto_err, busy, cbus_tx_vld}, 3'b110);
      chk(prm_q == 64'h0, "R10", "busy parameter write ignored", prm_q, 0);
      for (int k = 0; k < 10 && busy; k++) begin
         cbus_rx_vld = 1'b1; cbus_rx_byte = 8'h11 * 8'(k + 1);
         @(negedge clk);
      end
      cbus_rx_vld = 1'b0;
      #1;
      chk(!busy && prm_q == 64'h0000_0000_4433_2211, "R4", "read after stray", prm_q, 64'h44332211);
      chk(proto_err, "R9", "error stays set", proto_err, 1);
      run(mkw(8'h01, 0, 0, 0, 0, 4'h0));
      chk(!proto_err, "R9", "error cleared by next command", proto_err, 0);
      end_checks("R9", 1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule